// File: doc/BRIEF.md
# Event Combiner and Priority Router

This block gathers 128 numbered event lines into twelve interrupt outputs, one for each maskable core priority level from 4 to 15. The events fall into four groups of 32. Each group latches its events into sticky flag bits, drops the masked ones and ORs the rest into one combined event. A per-group route field sends that combined event to any one of the twelve priority outputs.

Next to the combiners, a twelve-entry selector table lets each priority output take one event line directly. Event numbers 0 to 3 stand for the four combined events, so the inputs with those numbers are never latched and a selector value below 4 leaves its entry unused. An event that a selector entry takes directly no longer adds to its group's combined event. Its flag is still latched. Software sets the block up through a single-cycle register write port and reads state back through a registered read port.

Top module: `evt_route_top`

## Requirements
- R1: After a synchronous reset, all flags are 0, every mask bit is 1, every route field and every selector entry is 0, and irq_o is all zero.
- R2: An event n (4..127) that is high at a clock edge sets flag bit n%32 of group n/32, and the bit stays set. Inputs 0..3 never set a flag: bits 3:0 of group 0 always read as 0.
- R3: A write to a group's flag address clears the flag bits where the write data holds 1. If an event arrives on a bit in the same cycle as the clear, the bit stays set.
- R4: The combined event of group k is the OR of that group's flags that are neither masked nor bypassed. The flags used are the values after this cycle's events and clears. A mask bit of 1 excludes its event.
- R5: A group's route field (4 bits) with value v in 4..15 sends the group's combined event to irq_o[v-4]. A value from 0 to 3 sends it nowhere.
- R6: A selector entry j (7 bits) with value v in 4..127 drives irq_o[j] from event line v as a level, without the sticky flag. A value from 0 to 3 has no effect.
- R7: An event that any selector entry names directly is left out of its group's combined event.
- R8: When several sources target the same output (routed groups and/or a selector entry), that output is their OR.
- R9: irq_o is registered. An event that is high before clock edge t is seen on irq_o after edge t, and cfg_rdata shows the state addressed before edge t.
- R10: Register map on cfg_addr: 0..3 hold the flags of group 0..3, 4..7 the masks, 8..11 the route fields and 16..27 selector entries 0..11. Narrow fields read back zero-extended. Every other address reads 0, and writes to those addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 128 | Event lines, bit n is event n |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address for write and read |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data of the address from the previous cycle |
| irq_o | output | 12 | Priority outputs, bit j is core priority level j+4 |

## Verification
The hardest situation to reach from the ports is the one where a flag is latched but must not reach its output, because a selector entry names the same event. Here the combined event and the direct path point at different outputs. The bench reaches it directly: it unmasks a group, routes it to one output and selects one of its events onto another output. It then pulses that event, and later a neighbour in the same group, and compares both outputs. Random writes with a fixed seed then reshuffle masks, routes and selector entries while sparse random events run. This mixes bypass, merging and clear-versus-set collisions in many combinations.

// File: rtl/evt_route_pkg.sv
package evt_route_pkg;

  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    K_FLAG,
    K_MASK,
    K_ROUTE,
    K_SEL,
    K_NONE
  } reg_kind_e;

  // Address split: bit 4 selects the selector table, bits 3:2 pick the group bank
  function automatic reg_kind_e decode_kind(input logic [ADDR_W-1:0] a);
    if (a[4]) return K_SEL;
    case (a[3:2])
      2'd0:    return K_FLAG;
      2'd1:    return K_MASK;
      2'd2:    return K_ROUTE;
      default: return K_NONE;
    endcase
  endfunction

endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
  parameter int GRP_W  = 32,
  parameter int RSV_LO = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [GRP_W-1:0] evt_i,
  input  logic             clr_we,
  input  logic             mask_we,
  input  logic [GRP_W-1:0] wdata,
  input  logic [GRP_W-1:0] bypass_i,
  output logic [GRP_W-1:0] flag_o,
  output logic [GRP_W-1:0] mask_o,
  output logic             comb_o
);

  localparam logic [GRP_W-1:0] RSV_MASK =
    (RSV_LO == 0) ? '0 : GRP_W'((64'd1 << RSV_LO) - 64'd1);

  logic [GRP_W-1:0] flag_q, mask_q, flag_nxt, clr_bits;

  assign clr_bits = clr_we ? wdata : '0;
  // Set wins over a same-cycle clear; reserved low events never latch
  assign flag_nxt = ((flag_q & ~clr_bits) | evt_i) & ~RSV_MASK;
  assign comb_o   = |(flag_nxt & ~mask_q & ~bypass_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      mask_q <= '1;
    end else begin
      flag_q <= flag_nxt;
      if (mask_we) mask_q <= wdata;
    end
  end

  assign flag_o = flag_q;
  assign mask_o = mask_q;

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((flag_o & $past(wdata & ~evt_i)) == '0));

  // R2
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_we |=> ((flag_o & $past(flag_o)) == $past(flag_o)));

  // R2
  evt_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt_i) |=> ((flag_o & $past(evt_i & ~RSV_MASK)) == $past(evt_i & ~RSV_MASK)));

endmodule

// File: rtl/evt_sel_unit.sv
module evt_sel_unit #(
  parameter int NUM_EVT = 128,
  parameter int NUM_PRI = 12,
  parameter int RSV_EVT = 4,
  localparam int EVT_IDX_W = $clog2(NUM_EVT),
  localparam int SEL_IDX_W = $clog2(NUM_PRI)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [SEL_IDX_W-1:0] idx,
  input  logic [EVT_IDX_W-1:0] wdata,
  input  logic [NUM_EVT-1:0]   evt_i,
  output logic [EVT_IDX_W-1:0] sel_o [NUM_PRI],
  output logic [NUM_PRI-1:0]   direct_o,
  output logic [NUM_EVT-1:0]   bypass_o
);

  logic [EVT_IDX_W-1:0] sel_q [NUM_PRI];
  logic [NUM_PRI-1:0]   live;

  for (genvar j = 0; j < NUM_PRI; j++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)                             sel_q[j] <= '0;
      else if (we && idx == SEL_IDX_W'(j)) sel_q[j] <= wdata;
    end
    // Values below RSV_EVT name combined sources and leave the entry idle
    assign live[j]     = (int'(sel_q[j]) >= RSV_EVT);
    assign direct_o[j] = live[j] && evt_i[sel_q[j]];
    assign sel_o[j]    = sel_q[j];
  end

  always_comb begin
    bypass_o = '0;
    for (int j = 0; j < NUM_PRI; j++)
      if (live[j]) bypass_o[sel_q[j]] = 1'b1;
  end

endmodule

// File: rtl/evt_route_xbar.sv
module evt_route_xbar #(
  parameter int NUM_GRP  = 4,
  parameter int NUM_PRI  = 12,
  parameter int PRI_BASE = 4,
  localparam int PRI_W     = $clog2(PRI_BASE + NUM_PRI),
  localparam int GRP_IDX_W = $clog2(NUM_GRP)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 route_we,
  input  logic [GRP_IDX_W-1:0] route_idx,
  input  logic [PRI_W-1:0]     wdata,
  input  logic [NUM_GRP-1:0]   comb_i,
  input  logic [NUM_PRI-1:0]   direct_i,
  output logic [PRI_W-1:0]     route_o [NUM_GRP],
  output logic [NUM_PRI-1:0]   irq_o
);

  logic [PRI_W-1:0]   route_q [NUM_GRP];
  logic [NUM_PRI-1:0] routed, irq_q;

  for (genvar k = 0; k < NUM_GRP; k++) begin : g_route
    always_ff @(posedge clk) begin
      if (rst)                                         route_q[k] <= '0;
      else if (route_we && route_idx == GRP_IDX_W'(k)) route_q[k] <= wdata;
    end
    assign route_o[k] = route_q[k];
  end

  always_comb begin
    routed = '0;
    for (int k = 0; k < NUM_GRP; k++)
      for (int j = 0; j < NUM_PRI; j++)
        if (comb_i[k] && route_q[k] == PRI_W'(j + PRI_BASE)) routed[j] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= routed | direct_i;
  end

  assign irq_o = irq_q;

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_o == '0));

  // R6
  direct_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (|direct_i) |=> ((irq_o & $past(direct_i)) == $past(direct_i)));

  for (genvar k = 0; k < NUM_GRP; k++) begin : g_rchk
    for (genvar j = 0; j < NUM_PRI; j++) begin : g_pchk
      // R5
      route_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (comb_i[k] && route_q[k] == PRI_W'(j + PRI_BASE)) |=> irq_o[j]);
    end
  end

endmodule

// File: rtl/evt_route_top.sv
module evt_route_top
  import evt_route_pkg::*;
#(
  parameter int NUM_GRP  = 4,
  parameter int GRP_W    = 32,
  parameter int NUM_PRI  = 12,
  parameter int PRI_BASE = 4,
  localparam int NUM_EVT   = NUM_GRP * GRP_W,
  localparam int EVT_IDX_W = $clog2(NUM_EVT),
  localparam int PRI_W     = $clog2(PRI_BASE + NUM_PRI),
  localparam int GRP_IDX_W = $clog2(NUM_GRP),
  localparam int SEL_IDX_W = $clog2(NUM_PRI)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic [DATA_W-1:0]  cfg_rdata,
  output logic [NUM_PRI-1:0] irq_o
);

  reg_kind_e            kind;
  logic [GRP_IDX_W-1:0] grp_idx;
  logic [SEL_IDX_W-1:0] sel_idx;
  logic                 sel_hit;

  logic [GRP_W-1:0]     flag_w [NUM_GRP];
  logic [GRP_W-1:0]     mask_w [NUM_GRP];
  logic [NUM_GRP-1:0]   comb_w;
  logic [NUM_EVT-1:0]   bypass_w;
  logic [NUM_PRI-1:0]   direct_w;
  logic [EVT_IDX_W-1:0] sel_w   [NUM_PRI];
  logic [PRI_W-1:0]     route_w [NUM_GRP];
  logic [DATA_W-1:0]    rdata_q;

  assign kind    = decode_kind(cfg_addr);
  assign grp_idx = cfg_addr[GRP_IDX_W-1:0];
  assign sel_idx = cfg_addr[SEL_IDX_W-1:0];
  assign sel_hit = (kind == K_SEL) && (int'(cfg_addr[ADDR_W-2:0]) < NUM_PRI);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_bank
    evt_flag_bank #(
      .GRP_W  (GRP_W),
      .RSV_LO ((g == 0) ? NUM_GRP : 0)
    ) bank_i (
      .clk      (clk),
      .rst      (rst),
      .evt_i    (evt_i[g*GRP_W +: GRP_W]),
      .clr_we   (cfg_we && kind == K_FLAG && grp_idx == GRP_IDX_W'(g)),
      .mask_we  (cfg_we && kind == K_MASK && grp_idx == GRP_IDX_W'(g)),
      .wdata    (cfg_wdata[GRP_W-1:0]),
      .bypass_i (bypass_w[g*GRP_W +: GRP_W]),
      .flag_o   (flag_w[g]),
      .mask_o   (mask_w[g]),
      .comb_o   (comb_w[g])
    );
  end

  evt_sel_unit #(
    .NUM_EVT (NUM_EVT),
    .NUM_PRI (NUM_PRI),
    .RSV_EVT (NUM_GRP)
  ) sel_i (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we && sel_hit),
    .idx      (sel_idx),
    .wdata    (cfg_wdata[EVT_IDX_W-1:0]),
    .evt_i    (evt_i),
    .sel_o    (sel_w),
    .direct_o (direct_w),
    .bypass_o (bypass_w)
  );

  evt_route_xbar #(
    .NUM_GRP  (NUM_GRP),
    .NUM_PRI  (NUM_PRI),
    .PRI_BASE (PRI_BASE)
  ) xbar_i (
    .clk       (clk),
    .rst       (rst),
    .route_we  (cfg_we && kind == K_ROUTE),
    .route_idx (grp_idx),
    .wdata     (cfg_wdata[PRI_W-1:0]),
    .comb_i    (comb_w),
    .direct_i  (direct_w),
    .route_o   (route_w),
    .irq_o     (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (kind)
        K_FLAG:  rdata_q <= DATA_W'(flag_w[grp_idx]);
        K_MASK:  rdata_q <= DATA_W'(mask_w[grp_idx]);
        K_ROUTE: rdata_q <= DATA_W'(route_w[grp_idx]);
        K_SEL:   rdata_q <= sel_hit ? DATA_W'(sel_w[sel_idx]) : '0;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign cfg_rdata = rdata_q;

  // R7
  bypass_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (bypass_w[GRP_W-1:0] == flag_w[0] && mask_w[0] == '0 && evt_i[GRP_W-1:0] == '0
     && !(cfg_we && kind == K_FLAG)) |-> !comb_w[0]);

endmodule

// File: tb/evt_route_top_tb_top.sv
module evt_route_top_tb_top;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] evt_i = '0;
  logic         cfg_we = 1'b0;
  logic [4:0]   cfg_addr = '0;
  logic [31:0]  cfg_wdata = '0;
  logic [31:0]  cfg_rdata;
  logic [11:0]  irq_o;

  always #2 clk = ~clk;

  evt_route_top dut_i (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (evt_i),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .irq_o     (irq_o)
  );

  logic [31:0] m_flag [4];
  logic [31:0] m_mask [4];
  logic [3:0]  m_route [4];
  logic [6:0]  m_sel [12];

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  function automatic logic [127:0] model_bypass();
    logic [127:0] b = '0;
    for (int j = 0; j < 12; j++)
      if (m_sel[j] >= 7'd4) b[m_sel[j]] = 1'b1;
    return b;
  endfunction

  function automatic logic [31:0] model_read(input logic [4:0] a);
    if (a[4]) return (a[3:0] < 4'd12) ? {25'd0, m_sel[a[3:0]]} : 32'd0;
    case (a[3:2])
      2'd0:    return m_flag[a[1:0]];
      2'd1:    return m_mask[a[1:0]];
      2'd2:    return {28'd0, m_route[a[1:0]]};
      default: return 32'd0;
    endcase
  endfunction

  task automatic apply(input logic [127:0] ev, input logic we, input logic [4:0] a,
                       input logic [31:0] wd, input string tag);
    logic [31:0]  nf [4];
    logic [3:0]   comb;
    logic [127:0] byp;
    logic [11:0]  exp_irq;
    logic [31:0]  exp_rd;
    byp = model_bypass();
    for (int k = 0; k < 4; k++) begin
      logic [31:0] clr;
      clr = (we && a[4:2] == 3'd0 && a[1:0] == 2'(k)) ? wd : 32'd0;
      nf[k] = (m_flag[k] & ~clr) | ev[k*32 +: 32];
      if (k == 0) nf[k] = nf[k] & ~32'hF;
      comb[k] = |(nf[k] & ~m_mask[k] & ~byp[k*32 +: 32]);
    end
    exp_irq = '0;
    for (int j = 0; j < 12; j++) begin
      if (m_sel[j] >= 7'd4 && ev[m_sel[j]]) exp_irq[j] = 1'b1;
      for (int k = 0; k < 4; k++)
        if (comb[k] && m_route[k] == 4'(j + 4)) exp_irq[j] = 1'b1;
    end
    exp_rd = model_read(a);
    evt_i = ev; cfg_we = we; cfg_addr = a; cfg_wdata = wd;
    @(posedge clk);
    for (int k = 0; k < 4; k++) m_flag[k] = nf[k];
    if (we) begin
      if (a[4]) begin
        if (a[3:0] < 4'd12) m_sel[a[3:0]] = wd[6:0];
      end else if (a[3:2] == 2'd1) m_mask[a[1:0]] = wd;
      else if (a[3:2] == 2'd2) m_route[a[1:0]] = wd[3:0];
    end
    @(negedge clk);
    n_vec++;
    if (irq_o !== exp_irq) begin
      n_bad++;
      $display("FAIL %s irq_o actual %h expected %h", tag, irq_o, exp_irq);
    end
    n_vec++;
    if (cfg_rdata !== exp_rd) begin
      n_bad++;
      $display("FAIL %s cfg_rdata actual %h expected %h", tag, cfg_rdata, exp_rd);
    end
  endtask

  function automatic logic [127:0] bit_at(input int n);
    logic [127:0] v = '0;
    v[n] = 1'b1;
    return v;
  endfunction

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'd4242);
    for (int k = 0; k < 4; k++) begin
      m_flag[k] = '0; m_mask[k] = '1; m_route[k] = '0;
    end
    for (int j = 0; j < 12; j++) m_sel[j] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset values through readback and outputs
    apply('0, 0, 5'd4,  0, "R1");
    apply('0, 0, 5'd0,  0, "R1");
    apply('0, 0, 5'd9,  0, "R1");
    apply('0, 0, 5'd27, 0, "R1");

    // R2: capture and hold; inputs 0..3 never latch
    apply(bit_at(37), 0, 5'd1, 0, "R2");
    apply('0, 0, 5'd1, 0, "R2");
    apply('0, 0, 5'd1, 0, "R2");
    apply(128'hF, 0, 5'd0, 0, "R2");
    apply('0, 0, 5'd0, 0, "R2");

    // R3: clear by write-one, then set beats clear
    apply('0, 1, 5'd1, 32'h20, "R3");
    apply('0, 0, 5'd1, 0, "R3");
    apply(bit_at(38), 0, 5'd1, 0, "R3");
    apply(bit_at(38), 1, 5'd1, 32'h40, "R3");
    apply('0, 0, 5'd1, 0, "R3");
    apply('0, 1, 5'd1, 32'hFFFF_FFFF, "R3");

    // R4, R5: unmask group 1, route to level 12 (irq_o[8])
    apply('0, 1, 5'd5, 32'h0, "R4");
    apply('0, 1, 5'd9, 32'd12, "R5");
    apply(bit_at(40), 0, 5'd9, 0, "R5");
    apply('0, 0, 5'd1, 0, "R4");
    apply('0, 1, 5'd5, 32'h0000_0100, "R4");
    apply('0, 0, 5'd1, 0, "R4");
    apply('0, 1, 5'd1, 32'hFFFF_FFFF, "R4");
    apply('0, 1, 5'd5, 32'h0, "R4");
    apply('0, 1, 5'd9, 32'd2, "R5");
    apply(bit_at(41), 0, 5'd9, 0, "R5");
    apply('0, 1, 5'd1, 32'hFFFF_FFFF, "R5");

    // R6: direct level forwarding, unused entry
    apply('0, 1, 5'd20, 32'd70, "R6");
    apply(bit_at(70), 0, 5'd20, 0, "R6");
    apply(bit_at(70), 0, 5'd20, 0, "R6");
    apply('0, 0, 5'd20, 0, "R6");
    apply('0, 1, 5'd16, 32'd2, "R6");
    apply(128'hF, 0, 5'd16, 0, "R6");

    // R7: event 33 selected to entry 1, group 1 routed to 12
    apply('0, 1, 5'd9, 32'd12, "R7");
    apply('0, 1, 5'd17, 32'd33, "R7");
    apply(bit_at(33), 0, 5'd1, 0, "R7");
    apply('0, 0, 5'd1, 0, "R7");
    apply(bit_at(34), 0, 5'd1, 0, "R7");
    apply('0, 1, 5'd1, 32'hFFFF_FFFF, "R7");

    // R8: group 2 also to 12; group 1 to 5 alongside entry 1
    apply('0, 1, 5'd6, 32'h0, "R8");
    apply('0, 1, 5'd10, 32'd12, "R8");
    apply(bit_at(64) | bit_at(35), 0, 5'd2, 0, "R8");
    apply('0, 1, 5'd9, 32'd5, "R8");
    apply(bit_at(33) | bit_at(36), 0, 5'd1, 0, "R8");
    apply('0, 1, 5'd1, 32'hFFFF_FFFF, "R8");
    apply('0, 1, 5'd2, 32'hFFFF_FFFF, "R8");

    // R10: unmapped addresses read zero and ignore writes
    apply('0, 1, 5'd12, 32'hFFFF_FFFF, "R10");
    apply('0, 1, 5'd28, 32'd99, "R10");
    apply('0, 0, 5'd12, 0, "R10");
    apply('0, 0, 5'd31, 0, "R10");
    apply('0, 0, 5'd9, 0, "R10");

    // R9: random traffic, every cycle compared at its latency
    for (int i = 0; i < 4000; i++) begin
      logic [127:0] ev;
      logic         we;
      for (int g = 0; g < 4; g++) ev[g*32 +: 32] = $urandom & $urandom & $urandom;
      we = ($urandom % 6) == 0;
      apply(ev, we, 5'($urandom), $urandom, "R9");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule